// File: doc/BRIEF.md
# Write Channel Protocol Checker

This is a passive monitor for one AXI4 write interface. It observes the write-address handshake (valid, ready, burst length, transfer size and cache attributes) and the write-data handshake (valid, ready, last). It never drives the bus. It evaluates six rules every cycle. Each rule that fires sets its own sticky bit. For the same cycle the monitor emits a one-cycle pulse together with the lowest-numbered code among the rules that fired.

Burst lengths taken from accepted addresses enter a small in-order queue. Each data burst is compared with the oldest queued length when its final beat arrives. A burst can finish before its address has been accepted. In that case its beat count is held and checked in the cycle the address handshake takes place. A ready timeout of configurable length and a detector for runaway bursts with no end marker complete the checks. All outputs are registered and change on the clock edge after the cycle in which the offending stimulus is present.

Top module: `wr_chan_monitor`

## Requirements
- R1: After reset, `viol_sticky` is 0, `err_pulse` is 0 and `err_code` is 0.
- R2: Once `wvalid` is high with `wready` low, `wlast` keeps the value it had in the first such stalled cycle. Any cycle, up to and including the handshake cycle, in which `wlast` differs from that value fires rule code 1 (sticky bit 0).
- R3: Rule code 2 (sticky bit 1) fires once, in the MAX_WAIT-th consecutive cycle with `wvalid` high and `wready` low. A stall of MAX_WAIT-1 cycles does not fire it. The count restarts when `wvalid` drops or a handshake completes.
- R4: On a cycle where `awvalid` and `awready` are both high, `awcache[2]`=1 together with `awcache[1]`=0 fires code 3 (sticky bit 2). The same attributes without `awready` have no effect.
- R5: On an address handshake, 2^`awsize` bytes greater than DATA_BYTES fires code 4 (sticky bit 3).
- R6: The beat with `wlast` fires code 5 (sticky bit 4) when the number of accepted beats in the burst differs from the oldest queued `awlen`+1. Addresses are consumed in acceptance order.
- R7: A burst that completes while no address is queued is checked in the cycle its address is accepted. A mismatch fires code 5 in that cycle.
- R8: The 256th accepted beat without `wlast` (2^LEN_W beats) fires code 6 (sticky bit 5), independent of `awlen`.
- R9: When several rules fire in one cycle, `err_code` is the lowest code and every one of their sticky bits is set. `err_pulse` is high exactly when `err_code` is nonzero.
- R10: Sticky bits are cleared only by reset or by `clr_sticky`. A rule that fires in the same cycle as `clr_sticky` still ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_sticky | input | 1 | Clears the sticky violation bits |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awlen | input | LEN_W | Burst length minus one |
| awsize | input | 3 | log2 of bytes per beat |
| awcache | input | 4 | Cache attribute bits |
| wvalid | input | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wlast | input | 1 | Final beat marker |
| viol_sticky | output | 6 | Sticky rule bits; bit i is code i+1 |
| err_pulse | output | 1 | A rule fired in the previous cycle |
| err_code | output | 3 | Lowest code that fired, 0 if none |

## Verification
The end-marker stability rule and the ready timeout both watch the same stall. The bench holds a data beat stalled for MAX_WAIT cycles and toggles `wlast` in the last of them, so both rules fire in one cycle. It then expects code 1 and both sticky bits. The cache and size rules are also made to coincide on a single address handshake, which must report code 3 with bits 2 and 3 set. A runaway burst is closed with a last beat so that the length rule fires directly after the runaway rule.

// File: rtl/wcm_pkg.sv
package wcm_pkg;
  localparam int NUM_RULES = 6;

  typedef enum logic [2:0] {
    CODE_NONE     = 3'd0,
    CODE_LAST_CHG = 3'd1,
    CODE_RDY_TMO  = 3'd2,
    CODE_CACHE    = 3'd3,
    CODE_SIZE     = 3'd4,
    CODE_LEN      = 3'd5,
    CODE_RUNAWAY  = 3'd6
  } code_e;

  // Lowest fired rule wins: scan downward so the last hit is the smallest.
  function automatic logic [2:0] first_code(input logic [NUM_RULES-1:0] fired);
    logic [2:0] c;
    c = 3'd0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (fired[i]) c = 3'(i + 1);
    end
    return c;
  endfunction

  function automatic logic size_too_wide(input logic [2:0] sz, input int unsigned bus_bytes);
    return (32'd1 << sz) > bus_bytes;
  endfunction

  function automatic logic cache_alloc_bad(input logic [3:0] attr);
    return attr[2] & ~attr[1];
  endfunction

  function automatic logic burst_len_ok(input logic [15:0] nbeats, input logic [15:0] len_m1);
    return nbeats == (len_m1 + 16'd1);
  endfunction
endpackage

// File: rtl/wcm_hs_watch.sv
module wcm_hs_watch #(
  parameter int MAX_WAIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wvalid,
  input  logic wready,
  input  logic wlast,
  output logic lastchg_fire,
  output logic tmo_fire
);
  localparam int CW = $clog2(MAX_WAIT + 1);

  logic          wait_q;
  logic          ref_q;
  logic [CW-1:0] stall_q;
  logic          stall_now;

  assign stall_now    = wvalid & ~wready;
  assign lastchg_fire = wait_q & wvalid & (wlast != ref_q);
  assign tmo_fire     = stall_now & (stall_q == CW'(MAX_WAIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q  <= 1'b0;
      ref_q   <= 1'b0;
      stall_q <= '0;
    end else begin
      wait_q <= stall_now;
      if (stall_now && !wait_q) ref_q <= wlast;
      if (!stall_now)                       stall_q <= '0;
      else if (stall_q != CW'(MAX_WAIT))    stall_q <= stall_q + CW'(1);
    end
  end

  assert_lastchg_in_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lastchg_fire |-> ($past(wvalid) && !$past(wready)))
    else $error("end marker change flagged outside a stall");

  assert_timeout_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> !tmo_fire)
    else $error("timeout fired twice in a row");
endmodule

// File: rtl/wcm_len_fifo.sv
module wcm_len_fifo #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic             exp_valid,
  output logic [LEN_W-1:0] exp_len
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [LEN_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [NW-1:0]    cnt_q;
  logic             empty, do_wr, do_rd;

  assign empty     = (cnt_q == '0);
  assign exp_valid = !empty || push;
  assign exp_len   = empty ? push_len : mem[rd_q];
  assign do_wr     = push && !(empty && pop);
  assign do_rd     = pop && !empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_q] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wr_q <= bump(wr_q);
      if (do_rd) rd_q <= bump(rd_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + NW'(1);
        2'b01:   cnt_q <= cnt_q - NW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_queue_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NW'(DEPTH))
    else $error("length queue count above depth");
endmodule

// File: rtl/wcm_beat_track.sv
module wcm_beat_track
  import wcm_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wvalid,
  input  logic             wready,
  input  logic             wlast,
  input  logic             exp_valid,
  input  logic [LEN_W-1:0] exp_len,
  output logic             pop,
  output logic             len_fire,
  output logic             run_fire
);
  localparam int CW   = LEN_W + 2;
  localparam int MAXB = 1 << LEN_W;

  logic          beat, end_beat;
  logic [CW-1:0] cnt_q, n_now, hold_n_q;
  logic          hold_q;

  assign beat     = wvalid & wready;
  assign end_beat = beat & wlast;
  assign n_now    = cnt_q + CW'(1);
  assign run_fire = beat & ~wlast & (n_now == CW'(MAXB));

  always_comb begin
    pop      = 1'b0;
    len_fire = 1'b0;
    if (hold_q && exp_valid) begin
      pop      = 1'b1;
      len_fire = !burst_len_ok(16'(hold_n_q), 16'(exp_len));
    end else if (end_beat && exp_valid) begin
      pop      = 1'b1;
      len_fire = !burst_len_ok(16'(n_now), 16'(exp_len));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      hold_q   <= 1'b0;
      hold_n_q <= '0;
    end else begin
      if (beat) begin
        if (wlast)            cnt_q <= '0;
        else if (~&cnt_q)     cnt_q <= n_now;
      end
      if (hold_q && exp_valid) begin
        hold_q <= end_beat;
        if (end_beat) hold_n_q <= n_now;
      end else if (end_beat && !exp_valid) begin
        hold_q   <= 1'b1;
        hold_n_q <= n_now;
      end
    end
  end

  assert_runaway_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_fire |=> !run_fire)
    else $error("runaway rule fired on consecutive beats");
endmodule

// File: rtl/wr_chan_monitor.sv
module wr_chan_monitor
  import wcm_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int MAX_WAIT   = 16,
  parameter int QDEPTH     = 4,
  parameter int LEN_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_sticky,
  input  logic                 awvalid,
  input  logic                 awready,
  input  logic [LEN_W-1:0]     awlen,
  input  logic [2:0]           awsize,
  input  logic [3:0]           awcache,
  input  logic                 wvalid,
  input  logic                 wready,
  input  logic                 wlast,
  output logic [NUM_RULES-1:0] viol_sticky,
  output logic                 err_pulse,
  output logic [2:0]           err_code
);
  logic                 aw_hs;
  logic                 lastchg_fire, tmo_fire, cache_fire, size_fire, len_fire, run_fire;
  logic                 q_valid, q_pop;
  logic [LEN_W-1:0]     q_len;
  logic [NUM_RULES-1:0] fired;

  assign aw_hs      = awvalid & awready;
  assign cache_fire = aw_hs & cache_alloc_bad(awcache);
  assign size_fire  = aw_hs & size_too_wide(awsize, DATA_BYTES);

  wcm_hs_watch #(.MAX_WAIT(MAX_WAIT)) u_hs (
    .clk(clk), .rst_n(rst_n), .wvalid(wvalid), .wready(wready), .wlast(wlast),
    .lastchg_fire(lastchg_fire), .tmo_fire(tmo_fire)
  );

  wcm_len_fifo #(.DEPTH(QDEPTH), .LEN_W(LEN_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(aw_hs), .push_len(awlen), .pop(q_pop),
    .exp_valid(q_valid), .exp_len(q_len)
  );

  wcm_beat_track #(.LEN_W(LEN_W)) u_bt (
    .clk(clk), .rst_n(rst_n), .wvalid(wvalid), .wready(wready), .wlast(wlast),
    .exp_valid(q_valid), .exp_len(q_len), .pop(q_pop),
    .len_fire(len_fire), .run_fire(run_fire)
  );

  assign fired = {run_fire, len_fire, size_fire, cache_fire, tmo_fire, lastchg_fire};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_sticky <= '0;
      err_pulse   <= 1'b0;
      err_code    <= 3'd0;
    end else begin
      viol_sticky <= (clr_sticky ? '0 : viol_sticky) | fired;
      err_pulse   <= |fired;
      err_code    <= first_code(fired);
    end
  end

  assert_pulse_matches_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse == (err_code != 3'd0))
    else $error("pulse and code disagree");

  assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_sticky) |-> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)))
    else $error("sticky bit lost without clear");

  assert_cache_needs_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(awvalid && awready) |=> !(err_pulse && err_code == 3'd3))
    else $error("cache rule reported without address handshake");
endmodule

// File: tb/wr_chan_monitor_tb.sv
`timescale 1ns/100ps
module wr_chan_monitor_tb;
  localparam int MW = 16;

  logic clk = 1'b0, rst_n = 1'b0, clr_sticky = 1'b0;
  logic awvalid = 0, awready = 0, wvalid = 0, wready = 0, wlast = 0;
  logic [7:0] awlen = '0;
  logic [2:0] awsize = 3'd3;
  logic [3:0] awcache = 4'b0011;
  logic [5:0] viol_sticky;
  logic err_pulse;
  logic [2:0] err_code;

  int total = 0, bad = 0;

  typedef struct { logic [5:0] mask; logic clr; string req; } item_t;
  item_t sbq[$];
  item_t it;
  logic [5:0] model_st = '0;

  always #2.5 clk = ~clk;

  wr_chan_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .clr_sticky(clr_sticky),
    .awvalid(awvalid), .awready(awready), .awlen(awlen), .awsize(awsize), .awcache(awcache),
    .wvalid(wvalid), .wready(wready), .wlast(wlast),
    .viol_sticky(viol_sticky), .err_pulse(err_pulse), .err_code(err_code)
  );

  function automatic logic [2:0] want_code(input logic [5:0] m);
    logic [2:0] c = 3'd0;
    for (int i = 0; i < 6; i++) if (m[i] && c == 3'd0) c = 3'(i + 1);
    return c;
  endfunction

  // monitor: pops one expectation per cycle, just after the edge
  always @(posedge clk) begin
    #1;
    if (sbq.size() != 0) begin
      it = sbq.pop_front();
      model_st = (it.clr ? 6'd0 : model_st) | it.mask;
      total++;
      if (err_code !== want_code(it.mask) || err_pulse !== (it.mask != 0) || viol_sticky !== model_st) begin
        bad++;
        $display("FAIL %s: code=%0d pulse=%0b sticky=%b expected code=%0d pulse=%0b sticky=%b",
                 it.req, err_code, err_pulse, viol_sticky, want_code(it.mask), (it.mask != 0), model_st);
      end
    end
  end

  task automatic step(input logic [5:0] m, input string r);
    item_t x;
    x.mask = m; x.clr = clr_sticky; x.req = r;
    sbq.push_back(x);
    @(negedge clk);
  endtask

  task automatic idle();
    awvalid = 0; awready = 0; wvalid = 0; wready = 0; wlast = 0; clr_sticky = 0;
    awcache = 4'b0011; awsize = 3'd3;
  endtask

  task automatic aw(input logic [7:0] len);
    idle(); awvalid = 1; awready = 1; awlen = len;
  endtask

  task automatic beat(input logic last);
    idle(); wvalid = 1; wready = 1; wlast = last;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    total++;
    if (viol_sticky !== 0 || err_pulse !== 0 || err_code !== 0) begin
      bad++;
      $display("FAIL R1: sticky=%b pulse=%0b code=%0d expected all zero", viol_sticky, err_pulse, err_code);
    end

    // clean burst, len 1
    aw(8'd1);    step(6'h00, "R6 clean addr");
    beat(0);     step(6'h00, "R6 clean beat");
    beat(1);     step(6'h00, "R6 clean last");

    // R4: attributes without awready ignored, then with handshake
    idle(); awvalid = 1; awcache = 4'b0100; step(6'h00, "R4 no handshake ignored");
    aw(8'd0); awcache = 4'b0100; step(6'h04, "R4 cache rule");
    beat(1);     step(6'h00, "R4 consume");

    // R5: size 16 bytes on 8-byte bus; size 8 is fine
    aw(8'd0); awsize = 3'd4; step(6'h08, "R5 too wide");
    beat(1);     step(6'h00, "R5 consume");
    aw(8'd0); awsize = 3'd3; step(6'h00, "R5 equal width ok");
    beat(1);     step(6'h00, "R5 consume");

    // R9: cache and size together -> code 3
    aw(8'd0); awsize = 3'd5; awcache = 4'b0101; step(6'h0C, "R9 cache+size");
    beat(1);     step(6'h00, "R9 consume");

    // R2 + R3 coincide
    aw(8'd0);    step(6'h00, "R2 addr");
    idle(); wvalid = 1; wlast = 0;
    for (int i = 0; i < MW - 1; i++) step(6'h00, "R3 stall below limit");
    wlast = 1;   step(6'h03, "R2 R3 same cycle");
    wready = 1;  step(6'h01, "R2 change at handshake");

    // R3 edge: MW-1 stall cycles then ready
    aw(8'd0);    step(6'h00, "R3 addr");
    idle(); wvalid = 1; wlast = 1;
    for (int i = 0; i < MW - 1; i++) step(6'h00, "R3 edge stall");
    wready = 1;  step(6'h00, "R3 ready in time");

    // R6: short and long bursts
    aw(8'd2);    step(6'h00, "R6 short addr");
    beat(0);     step(6'h00, "R6 short b0");
    beat(1);     step(6'h10, "R6 short last");
    aw(8'd0);    step(6'h00, "R6 long addr");
    beat(0);     step(6'h00, "R6 long b0");
    beat(1);     step(6'h10, "R6 long last");

    // R6 ordering: two queued lengths
    aw(8'd0);    step(6'h00, "R6 order a0");
    aw(8'd1);    step(6'h00, "R6 order a1");
    beat(1);     step(6'h00, "R6 order burst0");
    beat(0);     step(6'h00, "R6 order burst1 b0");
    beat(1);     step(6'h00, "R6 order burst1 last");

    // R7: data before address
    beat(1);     step(6'h00, "R7 early burst ok");
    aw(8'd0);    step(6'h00, "R7 late addr match");
    beat(1);     step(6'h00, "R7 early burst bad");
    aw(8'd1);    step(6'h10, "R7 late addr mismatch");

    // R8: runaway
    aw(8'd255);  step(6'h00, "R8 addr");
    for (int i = 0; i < 255; i++) begin beat(0); step(6'h00, "R8 beats"); end
    beat(0);     step(6'h20, "R8 256th beat");
    beat(1);     step(6'h10, "R8 closing length");

    // R10: clear with a simultaneous fire, then plain clear
    aw(8'd0); awcache = 4'b0100; clr_sticky = 1; step(6'h04, "R10 clear with fire");
    beat(1);     step(6'h00, "R10 consume");
    idle(); clr_sticky = 1; step(6'h00, "R10 clear all");
    idle();      step(6'h00, "R10 stays clear");

    idle();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule